// File: doc/BRIEF.md
# Four-Wire Serial Control Register Port

This block is a slave serial port that gives an external controller access to a small bank of byte-wide control registers. A transaction opens when the active-low chip select goes low. The first byte shifted in is a command byte that selects the direction and the first register. Each later byte either loads the register at the current address or returns that register's contents on the serial output. The address steps forward by one after every byte.

The serial clock, chip select and data input are brought into the system clock domain through a synchroniser, and SCK edges are found there. The system clock must be at least four times faster than SCK, so that each SCK phase lasts two or more system clocks. A state machine controls the transaction. It has four states. ST_IDLE means chip select is high, or has just been seen low. ST_CMD means the command byte is being collected. ST_WRITE and ST_READ are the data phases.

The transitions are as follows. ST_IDLE→ST_CMD happens when chip select is seen low. ST_CMD→ST_WRITE or ST_CMD→ST_READ happens on the eighth SCK rising edge, chosen by the direction bit. Any state→ST_IDLE happens when chip select is seen high. The nine writable registers drive the block's configuration outputs. Two further addresses return fixed identification values.

Top module: `sreg_port`

## Requirements
- R1: After reset, register 00h holds FDh, register 01h holds C0h, and registers 02h to 08h hold 00h.
- R2: The first byte after chip select falls is the command byte. Bit 7 = 1 selects write and bit 7 = 0 selects read. Bits 4:0 give the start address. Bits 6:5 have no effect.
- R3: Every byte on SDI and SDO is sent least significant bit first. SDI is sampled on the SCK rising edge.
- R4: The address advances by one after each completed data byte, and wraps from 1Fh to 00h.
- R5: In write mode, each completed data byte is stored at the current address (00h to 08h), and the new value appears on ctrl_q bits [8*a+7:8*a].
- R6: In read mode, SDI data is ignored and no register changes.
- R7: Address 09h reads 13h and address 0Ah reads 19h. Writes to either address have no effect.
- R8: Writes to addresses 0Bh to 1Fh have no effect, and reads from those addresses return 00h.
- R9: SDO changes only after an SCK falling edge during read data bytes. SDO is 0 during the command byte and while chip select is high.
- R10: Chip select rising before a byte completes discards that partial byte, including when the rise coincides with the eighth SCK rising edge. The next byte is then taken as a command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| sck | input | 1 | Serial clock from the controller |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| ctrl_q | output | NUM_RW*8 | Writable registers, register a at bits [8*a+7:8*a] |

## Verification
Two events can land in the same synchronised cycle: chip select rising, and the eighth SCK rising edge that would complete a data byte. The bench provokes this by changing both pins on the same system-clock edge during the last bit of a write byte. It then judges the result at ctrl_q: the target register must keep its old value, and the next transaction must be parsed as a fresh command. Address wrap is also checked in combination with the read mux, by starting a read at 1Fh.

// File: rtl/sreg_pkg.sv
`timescale 1ns/1ps
package sreg_pkg;
    localparam int unsigned BYTE_W   = 8;
    localparam int unsigned ADDR_W   = 5;
    localparam int unsigned BIT_W    = $clog2(BYTE_W);
    localparam logic [ADDR_W-1:0] ID_LO_ADDR = 5'h09;
    localparam logic [ADDR_W-1:0] ID_HI_ADDR = 5'h0A;
    localparam logic [BYTE_W-1:0] ID_LO_VAL  = 8'h13;
    localparam logic [BYTE_W-1:0] ID_HI_VAL  = 8'h19;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CMD   = 2'd1,
        ST_WRITE = 2'd2,
        ST_READ  = 2'd3
    } port_state_e;

    // power-up value of each writable register
    function automatic logic [BYTE_W-1:0] reset_value(input int idx);
        case (idx)
            0:       return 8'hFD;
            1:       return 8'hC0;
            default: return '0;
        endcase
    endfunction
endpackage

// File: rtl/sreg_sync.sv
`timescale 1ns/1ps
module sreg_sync #(
    parameter int unsigned STAGES = 2,
    parameter int unsigned WIDTH  = 3,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        logic [WIDTH-1:0] q;
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) q <= RST_VAL;
                else        q <= d_i;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) q <= RST_VAL;
                else        q <= g_stage[s-1].q;
            end
        end
    end

    assign q_o = g_stage[STAGES-1].q;
endmodule

// File: rtl/sreg_fsm.sv
`timescale 1ns/1ps
module sreg_fsm
    import sreg_pkg::*;
#(
    parameter int unsigned NUM_RW = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csn_s,
    input  logic              sck_s,
    input  logic              sdi_s,
    input  logic [BYTE_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [BYTE_W-1:0] wr_data,
    output logic              sdo,
    output port_state_e       state_o,
    output logic [BIT_W-1:0]  bit_cnt_o
);
    port_state_e       state_q, state_d;
    logic              sck_prev_q;
    logic [BIT_W-1:0]  bit_q;
    logic [BYTE_W-1:0] rx_q;
    logic [BYTE_W-1:0] tx_q;
    logic [ADDR_W-1:0] addr_q, addr_next;
    logic              wr_en_q;
    logic [ADDR_W-1:0] wr_addr_q;
    logic [BYTE_W-1:0] wr_data_q;
    logic              sdo_q;

    logic              rise, fall, byte_done, cmd_phase;
    logic [BYTE_W-1:0] byte_full;

    assign rise      = sck_s & ~sck_prev_q;
    assign fall      = ~sck_s & sck_prev_q;
    assign byte_full = {sdi_s, rx_q[BYTE_W-1:1]};
    assign byte_done = rise && (bit_q == BIT_W'(BYTE_W-1));
    assign cmd_phase = (state_q == ST_IDLE) || (state_q == ST_CMD);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (csn_s) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = byte_done ? (byte_full[BYTE_W-1] ? ST_WRITE : ST_READ)
                                              : ST_CMD;
                ST_CMD:   if (byte_done)
                              state_d = byte_full[BYTE_W-1] ? ST_WRITE : ST_READ;
                ST_WRITE: state_d = ST_WRITE;
                ST_READ:  state_d = ST_READ;
            endcase
        end
    end

    // address that the next byte will use
    always_comb begin
        addr_next = addr_q;
        if (!csn_s && byte_done) begin
            if (cmd_phase) addr_next = byte_full[ADDR_W-1:0];
            else           addr_next = addr_q + 1'b1;
        end
    end

    assign rd_addr = addr_next;

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_prev_q <= 1'b0;
            bit_q      <= '0;
            rx_q       <= '0;
            tx_q       <= '0;
            addr_q     <= '0;
            wr_en_q    <= 1'b0;
            wr_addr_q  <= '0;
            wr_data_q  <= '0;
            sdo_q      <= 1'b0;
        end else begin
            sck_prev_q <= sck_s;
            wr_en_q    <= 1'b0;
            if (csn_s) begin
                bit_q <= '0;
                sdo_q <= 1'b0;
            end else begin
                if (rise) begin
                    rx_q  <= byte_full;
                    bit_q <= bit_q + 1'b1;
                end
                if (byte_done) begin
                    addr_q <= addr_next;
                    unique case (state_q)
                        ST_IDLE, ST_CMD: begin
                            tx_q <= rd_data;
                        end
                        ST_WRITE: begin
                            wr_en_q   <= (addr_q < ADDR_W'(NUM_RW));
                            wr_addr_q <= addr_q;
                            wr_data_q <= byte_full;
                        end
                        ST_READ: begin
                            tx_q <= rd_data;
                        end
                    endcase
                end
                if (fall && state_q == ST_READ) begin
                    sdo_q <= tx_q[0];
                    tx_q  <= {1'b0, tx_q[BYTE_W-1:1]};
                end
            end
        end
    end

    assign wr_en     = wr_en_q;
    assign wr_addr   = wr_addr_q;
    assign wr_data   = wr_data_q;
    assign sdo       = sdo_q;
    assign state_o   = state_q;
    assign bit_cnt_o = bit_q;
endmodule

// File: rtl/sreg_bank.sv
`timescale 1ns/1ps
module sreg_bank
    import sreg_pkg::*;
#(
    parameter int unsigned NUM_RW = 9
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [BYTE_W-1:0]        wr_data,
    input  logic [ADDR_W-1:0]        rd_addr,
    output logic [BYTE_W-1:0]        rd_data,
    output logic [NUM_RW*BYTE_W-1:0] regs_flat
);
    logic [BYTE_W-1:0] regs [NUM_RW];

    for (genvar g = 0; g < NUM_RW; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                regs[g] <= reset_value(g);
            else if (wr_en && wr_addr == ADDR_W'(g))
                regs[g] <= wr_data;
        end
        assign regs_flat[g*BYTE_W +: BYTE_W] = regs[g];
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_RW; i++) begin
            if (rd_addr == ADDR_W'(i)) rd_data = regs[i];
        end
        if (rd_addr == ID_LO_ADDR) rd_data = ID_LO_VAL;
        if (rd_addr == ID_HI_ADDR) rd_data = ID_HI_VAL;
    end
endmodule

// File: rtl/sreg_port.sv
`timescale 1ns/1ps
module sreg_port
    import sreg_pkg::*;
#(
    parameter int unsigned NUM_RW      = 9,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cs_n,
    input  logic                     sck,
    input  logic                     sdi,
    output logic                     sdo,
    output logic [NUM_RW*BYTE_W-1:0] ctrl_q
);
    logic              csn_s, sck_s, sdi_s;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr, rd_addr;
    logic [BYTE_W-1:0] wr_data, rd_data;
    port_state_e       fsm_state;
    logic [BIT_W-1:0]  bit_cnt;

    sreg_sync #(
        .STAGES (SYNC_STAGES),
        .WIDTH  (3),
        .RST_VAL(3'b100)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  ({cs_n, sck, sdi}),
        .q_o  ({csn_s, sck_s, sdi_s})
    );

    sreg_fsm #(.NUM_RW(NUM_RW)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .csn_s    (csn_s),
        .sck_s    (sck_s),
        .sdi_s    (sdi_s),
        .rd_data  (rd_data),
        .rd_addr  (rd_addr),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .sdo      (sdo),
        .state_o  (fsm_state),
        .bit_cnt_o(bit_cnt)
    );

    sreg_bank #(.NUM_RW(NUM_RW)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .regs_flat(ctrl_q)
    );
endmodule

// File: rtl/sreg_port_chk.sv
`timescale 1ns/1ps
module sreg_port_chk
    import sreg_pkg::*;
#(
    parameter int unsigned NUM_RW = 9
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     cs_n,
    input logic                     sdo,
    input logic [NUM_RW*BYTE_W-1:0] ctrl_q,
    input logic                     wr_en,
    input logic [ADDR_W-1:0]        wr_addr,
    input port_state_e              state
);
    AST_SDO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !sdo); // R9

    AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3) && $past(cs_n, 4))
        |-> $stable(ctrl_q)); // R10

    AST_WR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_addr < ADDR_W'(NUM_RW))); // R8

    AST_READ_NO_WR: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_READ) |-> !wr_en); // R6

    AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en); // R5
endmodule

bind sreg_port sreg_port_chk #(.NUM_RW(NUM_RW)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .cs_n   (cs_n),
    .sdo    (sdo),
    .ctrl_q (ctrl_q),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .state  (fsm_state)
);

// File: tb/sreg_port_bench.sv
`timescale 1ns/1ps
module sreg_port_bench;
    localparam int NRW = 9;
    localparam int HALF = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic sck = 1'b1;
    logic sdi = 1'b0;
    logic sdo;
    logic [NRW*8-1:0] ctrl_q;

    int total = 0;
    int bad = 0;
    logic [7:0] model [0:10];

    always #2.5 clk = ~clk;

    sreg_port #(.NUM_RW(NRW)) u_sreg_port (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi),
        .sdo(sdo), .ctrl_q(ctrl_q)
    );

    function automatic logic [7:0] exp_rd(input int a);
        if (a <= 10) return model[a];
        return 8'h00;
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic check_ctrl(input string req);
        for (int i = 0; i < NRW; i++) check(req, ctrl_q[i*8 +: 8], model[i]);
    endtask

    // one byte, LSB first; returns sampled SDO and whether it held through the high phase
    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx, output logic steady);
        logic late;
        steady = 1'b1;
        for (int i = 0; i < 8; i++) begin
            sck = 1'b0;
            sdi = tx[i];
            repeat (HALF) @(negedge clk);
            rx[i] = sdo;
            sck = 1'b1;
            repeat (HALF) @(negedge clk);
            late = sdo;
            if (late !== rx[i]) steady = 1'b0;
        end
    endtask

    task automatic open_x();
        @(negedge clk);
        cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic close_x();
        repeat (2) @(negedge clk);
        cs_n = 1'b1;
        repeat (8) @(negedge clk);
        check("R9 idle sdo", {7'b0, sdo}, 8'h00);
    endtask

    task automatic send_cmd(input logic [7:0] cmd);
        logic [7:0] rx;
        logic st;
        xfer(cmd, rx, st);
        check("R9 sdo during command", rx, 8'h00);
    endtask

    task automatic wr_byte(inout int a, input logic [7:0] d);
        logic [7:0] rx;
        logic st;
        xfer(d, rx, st);
        if (a < NRW) model[a] = d;
        a = (a + 1) & 31;
    endtask

    task automatic rd_byte(inout int a, input logic [7:0] junk, input string req);
        logic [7:0] rx;
        logic st;
        xfer(junk, rx, st);
        check(req, rx, exp_rd(a));
        check("R9 sdo steady while sck high", {7'b0, st}, 8'h01);
        a = (a + 1) & 31;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int a;
        logic [7:0] rx;
        logic st;
        void'($urandom(32'd2024));
        for (int i = 0; i < 11; i++) model[i] = 8'h00;
        model[0] = 8'hFD; model[1] = 8'hC0; model[9] = 8'h13; model[10] = 8'h19;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check_ctrl("R1 reset values");
        check("R9 sdo after reset", {7'b0, sdo}, 8'h00);

        // R1 R7 R4: read the whole map from 00h
        open_x(); send_cmd(8'h00); a = 0;
        for (int k = 0; k < 12; k++) rd_byte(a, 8'hFF, "R1 R7 R4 read map");
        close_x();

        // R5 R3: asymmetric patterns written at 03h
        open_x(); send_cmd(8'h83); a = 3;
        wr_byte(a, 8'h1E); wr_byte(a, 8'h07);
        close_x();
        check_ctrl("R5 R3 write burst");

        // R2 R6: read with bits 6:5 set, SDI toggling
        open_x(); send_cmd(8'h63); a = 3;
        rd_byte(a, 8'hFF, "R2 R3 read back"); rd_byte(a, 8'h55, "R2 R3 read back");
        close_x();
        check_ctrl("R6 read leaves registers");

        // R7 R8: write over ID and unmapped addresses
        open_x(); send_cmd(8'h89); a = 9;
        for (int k = 0; k < 5; k++) wr_byte(a, 8'hA0 + 8'(k));
        close_x();
        check_ctrl("R7 R8 ignored writes");
        open_x(); send_cmd(8'h09); a = 9;
        for (int k = 0; k < 4; k++) rd_byte(a, 8'h00, "R7 R8 id and unmapped reads");
        close_x();

        // R4: wrap from 1Fh to 00h
        open_x(); send_cmd(8'h1F); a = 31;
        rd_byte(a, 8'h00, "R8 read 1Fh"); rd_byte(a, 8'h00, "R4 wrap to 00h");
        close_x();

        // R10: partial byte then abort
        open_x();
        for (int i = 0; i < 3; i++) begin
            sck = 1'b0; sdi = 1'b1; repeat (HALF) @(negedge clk);
            sck = 1'b1; repeat (HALF) @(negedge clk);
        end
        close_x();
        open_x(); send_cmd(8'h82); a = 2; wr_byte(a, 8'h5A); close_x();
        check_ctrl("R10 command after abort");

        // R10: chip select rises together with the eighth SCK rise
        open_x(); send_cmd(8'h85);
        for (int i = 0; i < 8; i++) begin
            sck = 1'b0; sdi = 1'(i & 1); repeat (HALF) @(negedge clk);
            sck = 1'b1;
            if (i == 7) cs_n = 1'b1;
            repeat (HALF) @(negedge clk);
        end
        repeat (8) @(negedge clk);
        check_ctrl("R10 collision discards byte");
        open_x(); send_cmd(8'h05); a = 5; rd_byte(a, 8'h00, "R10 fresh command"); close_x();

        // random traffic
        for (int t = 0; t < 60; t++) begin
            logic wr;
            int n;
            logic [7:0] cmd;
            wr = 1'($urandom_range(1));
            a = int'($urandom_range(31));
            n = int'($urandom_range(4, 1));
            cmd = {wr, 2'($urandom_range(3)), 5'(a)};
            open_x(); send_cmd(cmd);
            for (int k = 0; k < n; k++) begin
                if (wr) wr_byte(a, 8'($urandom_range(255)));
                else    rd_byte(a, 8'($urandom_range(255)), "R2 R4 R6 random read");
            end
            close_x();
            check_ctrl("R5 R8 random state");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule